// File: doc/BRIEF.md
# I2C Host Command and Acknowledge Controller

This block is the register-facing control layer of an I2C host. Software reaches it through a byte-wide register port with a control register, an address register, a data register and a read-only status register. The block turns register writes and reads into single-cycle requests to a separate bit engine. That engine does the actual signalling on the wires and reports back through a done pulse, a bus-free level and a received byte.

Every bus command pairs two steps. First it applies the pending acknowledge decision, either ACK or NACK. Then it starts the next bus operation: a repeated start, a byte read or a stop. When the engine is busy, commands wait in a single pending slot, and a newer command replaces the one waiting there. Byte writes follow a different path. They are released only by a write to the data register, and only after the address phase has gone out. In smart mode, a software read of the data register requests the next byte read with its acknowledge, so no command write is needed. A flush strobe drops all transaction state and signals the engine to return to idle.

Register indices on `reg_addr_i`: 0 = control, 1 = address, 2 = data, 3 = status. Control bits: [1:0] command, [2] acknowledge select (1 = NACK), [3] flush, [4] smart mode. Address bit 0 is the transfer direction (1 = read). Status bits: [0] engine busy, [1] data-before-address flag, [2] bus owned, [3] command pending. Engine operation codes on `eng_op_o`: 0 = start plus address, 1 = repeated start, 2 = byte read, 3 = byte write, 4 = stop.

Top module: `i2ch_ctrl`

## Requirements
- R1: After reset no request or flush is driven, and the control, status, address and data registers all read 0.
- R2: Command code 1 requests a repeated start (op 1) and code 3 requests a stop (op 4). Both carry ack_en=1 and nack equal to control bit 2. Code 0 requests nothing. A stop clears status bit 2.
- R3: Command code 2 with address bit 0 = 1 requests a byte read (op 2) with ack_en=1. With address bit 0 = 0, the same code produces no request.
- R4: Control reads return bit 2 and bit 4 as last written, and always return bits [1:0] and bit 3 as zero.
- R5: When the acknowledge select and a command are written in the same control write, that command uses the new acknowledge value.
- R6: When smart mode is on (control bit 4) and address bit 0 = 1, a data register read requests a byte read (op 2) with ack_en=1 and nack taken from control bit 2. When smart mode is off, a data read requests nothing.
- R7: A byte write (op 3) is requested only after a data register write, only while the bus is owned and the direction is write. It carries the written byte and ack_en=0.
- R8: An address register write requests start-plus-address (op 0) with the address on eng_byte_o. The request is made only when bus_free_i is 1 or the bus is already owned, and it marks the bus owned.
- R9: A control write with bit 3 = 1 pulses eng_flush_o for one cycle. It drops the pending command, any pending byte write, busy, ownership and the data-before-address flag, and the command in that write is ignored. Writing bit 3 = 0 leaves that state unchanged.
- R10: After reset or a flush, a data write made before any address write sets status bit 1. That byte is sent (op 3) only after the start-plus-address request.
- R11: A command made while the engine is busy is held (status bit 3) and issued after eng_done_i. A later command overwrites the held one.
- R12: eng_req_o is high for exactly one cycle. No new request is issued while a request is outstanding and eng_done_i has not been seen.
- R13: The byte on eng_rx_i at the done of a byte read is returned by later data register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (has side effects on the data register) |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| bus_free_i | input | 1 | Bus idle indication from the engine |
| eng_done_i | input | 1 | Engine finished the outstanding request |
| eng_rx_i | input | 8 | Byte received by the engine |
| eng_req_o | output | 1 | One-cycle request to the engine |
| eng_op_o | output | 3 | Operation code of the request |
| eng_ack_en_o | output | 1 | Drive an acknowledge before the operation |
| eng_nack_o | output | 1 | Acknowledge value: 1 = NACK |
| eng_byte_o | output | 8 | Address or data byte of the request |
| eng_flush_o | output | 1 | One-cycle strobe telling the engine to go idle |

## Verification
The bench targets several orderings that a faulty controller would get wrong. One is a data byte written before its address: a broken design would put the byte on the bus ahead of the start and leave the invalid flag clear. Another is two commands arriving while the engine is busy: a broken design would issue the stale stop, or would issue a request on top of the one still in flight. A third is a flush bundled with a stop command: a broken design would still request the stop, or would keep bus ownership and a busy flag that block the next transaction. Smart-mode data reads, a read command in write direction, and acknowledge values written together with their command are each checked, so that a missing or wrongly valued acknowledge shows up as a mismatch on the request fields.

// File: rtl/i2ch_pkg.sv
package i2ch_pkg;
  typedef enum logic [2:0] {
    OP_ADDR   = 3'd0,
    OP_RSTART = 3'd1,
    OP_READ   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_STOP   = 3'd4
  } eng_op_e;

  typedef struct packed {
    eng_op_e op;
    logic    ack_en;
    logic    nack;
  } req_t;

  localparam int IDX_CTRL = 0;
  localparam int IDX_ADDR = 1;
  localparam int IDX_DATA = 2;
  localparam int IDX_STAT = 3;

  localparam int BIT_ACK   = 2;
  localparam int BIT_FLUSH = 3;
  localparam int BIT_SMART = 4;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_RSTART = 2'd1;
  localparam logic [1:0] CMD_XFER = 2'd2;
  localparam logic [1:0] CMD_STOP = 2'd3;
endpackage

// File: rtl/i2ch_rst_sync.sv
module i2ch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/i2ch_regs.sv
module i2ch_regs import i2ch_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [3:0]    status_i,
  input  logic          rx_vld_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic          ld_v_o,
  output req_t          ld_req_o,
  output logic          addr_wr_o,
  output logic          data_wr_o,
  output logic          flush_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] tx_o
);
  logic          smart_q, smart_d;
  logic          ackact_q, ackact_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          wr_ctrl, wr_addr, wr_data, rd_smart;

  assign wr_ctrl  = wr_i && (idx_i == AW'(IDX_CTRL));
  assign wr_addr  = wr_i && (idx_i == AW'(IDX_ADDR));
  assign wr_data  = wr_i && (idx_i == AW'(IDX_DATA));
  assign rd_smart = rd_i && !wr_i && (idx_i == AW'(IDX_DATA)) && smart_q && addr_q[0];

  always_comb begin
    smart_d   = smart_q;
    ackact_d  = ackact_q;
    addr_d    = addr_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    ld_v_o    = 1'b0;
    ld_req_o  = '{op: OP_READ, ack_en: 1'b0, nack: 1'b0};
    addr_wr_o = 1'b0;
    data_wr_o = 1'b0;
    flush_o   = 1'b0;
    if (wr_ctrl) begin
      ackact_d = wdata_i[BIT_ACK];
      smart_d  = wdata_i[BIT_SMART];
      if (wdata_i[BIT_FLUSH]) begin
        flush_o = 1'b1;
      end else begin
        case (wdata_i[1:0])
          CMD_RSTART: begin
            ld_v_o   = 1'b1;
            ld_req_o = '{op: OP_RSTART, ack_en: 1'b1, nack: wdata_i[BIT_ACK]};
          end
          CMD_XFER: begin
            if (addr_q[0]) begin
              ld_v_o   = 1'b1;
              ld_req_o = '{op: OP_READ, ack_en: 1'b1, nack: wdata_i[BIT_ACK]};
            end
          end
          CMD_STOP: begin
            ld_v_o   = 1'b1;
            ld_req_o = '{op: OP_STOP, ack_en: 1'b1, nack: wdata_i[BIT_ACK]};
          end
          default: ;
        endcase
      end
    end
    if (wr_addr) begin
      addr_d    = wdata_i;
      addr_wr_o = 1'b1;
      ld_v_o    = 1'b1;
      ld_req_o  = '{op: OP_ADDR, ack_en: 1'b0, nack: 1'b0};
    end
    if (wr_data) begin
      tx_d      = wdata_i;
      data_wr_o = 1'b1;
    end
    if (rd_smart) begin
      ld_v_o   = 1'b1;
      ld_req_o = '{op: OP_READ, ack_en: 1'b1, nack: ackact_q};
    end
    if (rx_vld_i) rx_d = rx_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smart_q  <= 1'b0;
      ackact_q <= 1'b0;
      addr_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      smart_q  <= smart_d;
      ackact_q <= ackact_d;
      addr_q   <= addr_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      AW'(IDX_CTRL): begin
        rdata_o[BIT_ACK]   = ackact_q;
        rdata_o[BIT_SMART] = smart_q;
      end
      AW'(IDX_ADDR): rdata_o = addr_q;
      AW'(IDX_DATA): rdata_o = rx_q;
      default:       rdata_o[3:0] = status_i;
    endcase
  end

  assign addr_o = addr_q;
  assign tx_o   = tx_q;

  // R4: the strobe bits never stay visible in the control register
  p_strobe_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == AW'(IDX_CTRL)) |-> (rdata_o[1:0] == 2'b00 && !rdata_o[BIT_FLUSH]));
endmodule

// File: rtl/i2ch_issue.sv
module i2ch_issue import i2ch_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_v_i,
  input  req_t          ld_req_i,
  input  logic          addr_wr_i,
  input  logic          data_wr_i,
  input  logic          flush_i,
  input  logic          dir_rd_i,
  input  logic [DW-1:0] addr_byte_i,
  input  logic [DW-1:0] tx_byte_i,
  input  logic          bus_free_i,
  input  logic          eng_done_i,
  output logic          eng_req_o,
  output logic [2:0]    eng_op_o,
  output logic          eng_ack_en_o,
  output logic          eng_nack_o,
  output logic [DW-1:0] eng_byte_o,
  output logic          eng_flush_o,
  output logic          rx_vld_o,
  output logic [3:0]    status_o
);
  logic          slot_v_q, slot_v_d;
  req_t          slot_q, slot_d;
  logic          txp_q, txp_d;
  logic          busy_q, busy_d;
  logic          owned_q, owned_d;
  logic          seen_q, seen_d;
  logic          inval_q, inval_d;
  logic          req_q, req_d;
  eng_op_e       op_q, op_d;
  logic          ack_q, ack_d;
  logic          nack_q, nack_d;
  logic [DW-1:0] byte_q, byte_d;
  logic          fl_q, fl_d;
  logic          slot_go, tx_go;

  assign slot_go  = !busy_q && slot_v_q &&
                    (slot_q.op != OP_ADDR || bus_free_i || owned_q);
  assign tx_go    = !busy_q && !slot_v_q && txp_q && owned_q && !dir_rd_i;
  assign rx_vld_o = eng_done_i && busy_q && (op_q == OP_READ);

  always_comb begin
    slot_v_d = slot_v_q;
    slot_d   = slot_q;
    txp_d    = txp_q;
    busy_d   = busy_q;
    owned_d  = owned_q;
    seen_d   = seen_q;
    inval_d  = inval_q;
    op_d     = op_q;
    ack_d    = ack_q;
    nack_d   = nack_q;
    byte_d   = byte_q;
    req_d    = 1'b0;
    fl_d     = 1'b0;
    if (slot_go) begin
      req_d    = 1'b1;
      op_d     = slot_q.op;
      ack_d    = slot_q.ack_en;
      nack_d   = slot_q.nack;
      byte_d   = (slot_q.op == OP_ADDR || slot_q.op == OP_RSTART) ? addr_byte_i : '0;
      slot_v_d = 1'b0;
      busy_d   = 1'b1;
      if (slot_q.op == OP_ADDR) owned_d = 1'b1;
      if (slot_q.op == OP_STOP) owned_d = 1'b0;
    end else if (tx_go) begin
      req_d  = 1'b1;
      op_d   = OP_WRITE;
      ack_d  = 1'b0;
      nack_d = 1'b0;
      byte_d = tx_byte_i;
      txp_d  = 1'b0;
      busy_d = 1'b1;
    end else if (eng_done_i) begin
      busy_d = 1'b0;
    end
    if (ld_v_i) begin
      slot_v_d = 1'b1;
      slot_d   = ld_req_i;
    end
    if (data_wr_i) begin
      txp_d = 1'b1;
      if (!seen_q) inval_d = 1'b1;
    end
    if (addr_wr_i) seen_d = 1'b1;
    if (flush_i) begin
      slot_v_d = 1'b0;
      txp_d    = 1'b0;
      busy_d   = 1'b0;
      owned_d  = 1'b0;
      seen_d   = 1'b0;
      inval_d  = 1'b0;
      req_d    = 1'b0;
      fl_d     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q <= 1'b0;
      slot_q   <= '{op: OP_READ, ack_en: 1'b0, nack: 1'b0};
      txp_q    <= 1'b0;
      busy_q   <= 1'b0;
      owned_q  <= 1'b0;
      seen_q   <= 1'b0;
      inval_q  <= 1'b0;
      req_q    <= 1'b0;
      op_q     <= OP_ADDR;
      ack_q    <= 1'b0;
      nack_q   <= 1'b0;
      byte_q   <= '0;
      fl_q     <= 1'b0;
    end else begin
      slot_v_q <= slot_v_d;
      slot_q   <= slot_d;
      txp_q    <= txp_d;
      busy_q   <= busy_d;
      owned_q  <= owned_d;
      seen_q   <= seen_d;
      inval_q  <= inval_d;
      req_q    <= req_d;
      op_q     <= op_d;
      ack_q    <= ack_d;
      nack_q   <= nack_d;
      byte_q   <= byte_d;
      fl_q     <= fl_d;
    end
  end

  assign eng_req_o    = req_q;
  assign eng_op_o     = op_q;
  assign eng_ack_en_o = ack_q;
  assign eng_nack_o   = nack_q;
  assign eng_byte_o   = byte_q;
  assign eng_flush_o  = fl_q;
  assign status_o     = {slot_v_q, owned_q, inval_q, busy_q};

  p_req_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o |=> !eng_req_o);
  p_busy_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !eng_done_i) |=> !eng_req_o);
  p_write_owned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == OP_WRITE) |-> (owned_q && !eng_ack_en_o));
  p_addr_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == OP_ADDR) |-> ($past(bus_free_i) || $past(owned_q)));
  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!busy_q && !slot_v_q && !owned_q && !eng_req_o && eng_flush_o));
  p_read_acks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == OP_READ) |-> eng_ack_en_o);
endmodule

// File: rtl/i2ch_ctrl.sv
module i2ch_ctrl import i2ch_pkg::*; #(
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          bus_free_i,
  input  logic          eng_done_i,
  input  logic [DW-1:0] eng_rx_i,
  output logic          eng_req_o,
  output logic [2:0]    eng_op_o,
  output logic          eng_ack_en_o,
  output logic          eng_nack_o,
  output logic [DW-1:0] eng_byte_o,
  output logic          eng_flush_o
);
  logic          rst_s_n;
  logic          ld_v, addr_wr, data_wr, flush, rx_vld;
  req_t          ld_req;
  logic [DW-1:0] addr_q, tx_q;
  logic [3:0]    status;

  i2ch_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_s_n)
  );

  i2ch_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_s_n),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .idx_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .status_i(status), .rx_vld_i(rx_vld), .rx_byte_i(eng_rx_i),
    .ld_v_o(ld_v), .ld_req_o(ld_req), .addr_wr_o(addr_wr),
    .data_wr_o(data_wr), .flush_o(flush), .addr_o(addr_q), .tx_o(tx_q)
  );

  i2ch_issue #(.DW(DW)) u_issue (
    .clk_i(clk_i), .rst_ni(rst_s_n),
    .ld_v_i(ld_v), .ld_req_i(ld_req), .addr_wr_i(addr_wr),
    .data_wr_i(data_wr), .flush_i(flush), .dir_rd_i(addr_q[0]),
    .addr_byte_i(addr_q), .tx_byte_i(tx_q),
    .bus_free_i(bus_free_i), .eng_done_i(eng_done_i),
    .eng_req_o(eng_req_o), .eng_op_o(eng_op_o), .eng_ack_en_o(eng_ack_en_o),
    .eng_nack_o(eng_nack_o), .eng_byte_o(eng_byte_o), .eng_flush_o(eng_flush_o),
    .rx_vld_o(rx_vld), .status_o(status)
  );
endmodule

// File: tb/sim_i2ch_ctrl.sv
module sim_i2ch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] ra = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdv;
  logic       bus_free = 1'b0;
  logic       done_a = 1'b0, done_m = 1'b0;
  logic       done_w;
  logic [7:0] rx = '0;
  logic       req, ack_en, nack, fl;
  logic [2:0] op;
  logic [7:0] eb;

  int n_chk = 0, n_fail = 0;
  int auto_lat = 3;
  int cnt = 0;
  bit finished = 0;

  assign done_w = done_a | done_m;
  always #4 clk = ~clk;

  i2ch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdv), .bus_free_i(bus_free), .eng_done_i(done_w),
    .eng_rx_i(rx), .eng_req_o(req), .eng_op_o(op), .eng_ack_en_o(ack_en),
    .eng_nack_o(nack), .eng_byte_o(eng_byte_sink), .eng_flush_o(fl)
  );
  logic [7:0] eng_byte_sink;
  assign eb = eng_byte_sink;

  // engine responder
  always @(negedge clk) begin
    done_a = 1'b0;
    if (!rst_n) cnt = 0;
    else if (req && auto_lat > 0) cnt = auto_lat;
    else if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) done_a = 1'b1;
    end
  end

  // behavioural reference model, advanced on every rising edge
  bit m_slot_v, m_txp, m_busy, m_owned, m_seen, m_inval, m_smart, m_ack;
  int m_slot_op; bit m_slot_ae, m_slot_nk;
  bit [7:0] m_addr, m_tx;
  bit e_req, e_ae, e_nk, e_fl; int e_op; bit [7:0] e_byte;

  always @(posedge clk) begin
    bit ld, lae, lnk, flsh, gs, gt; int lop;
    if (!rst_n) begin
      {m_slot_v, m_txp, m_busy, m_owned, m_seen, m_inval, m_smart, m_ack} = '0;
      m_slot_op = 2; m_slot_ae = 0; m_slot_nk = 0; m_addr = 0; m_tx = 0;
      e_req = 0; e_ae = 0; e_nk = 0; e_fl = 0; e_op = 0; e_byte = 0;
    end else begin
      ld = 0; lop = 2; lae = 0; lnk = 0; flsh = 0;
      gs = !m_busy && m_slot_v && (m_slot_op != 0 || bus_free || m_owned);
      gt = !m_busy && !m_slot_v && m_txp && m_owned && !m_addr[0];
      e_req = 0; e_fl = 0;
      if (gs) begin
        e_req = 1; e_op = m_slot_op; e_ae = m_slot_ae; e_nk = m_slot_nk;
        e_byte = (m_slot_op <= 1) ? m_addr : 8'h00;
        m_slot_v = 0; m_busy = 1;
        if (m_slot_op == 0) m_owned = 1;
        if (m_slot_op == 4) m_owned = 0;
      end else if (gt) begin
        e_req = 1; e_op = 3; e_ae = 0; e_nk = 0; e_byte = m_tx; m_txp = 0; m_busy = 1;
      end else if (done_w) m_busy = 0;
      if (wr && ra == 2'd0) begin
        if (wd[3]) flsh = 1;
        else if (wd[1:0] == 2'd1) begin ld = 1; lop = 1; lae = 1; lnk = wd[2]; end
        else if (wd[1:0] == 2'd2 && m_addr[0]) begin ld = 1; lop = 2; lae = 1; lnk = wd[2]; end
        else if (wd[1:0] == 2'd3) begin ld = 1; lop = 4; lae = 1; lnk = wd[2]; end
      end
      if (wr && ra == 2'd1) begin ld = 1; lop = 0; lae = 0; lnk = 0; end
      if (rd && !wr && ra == 2'd2 && m_smart && m_addr[0]) begin
        ld = 1; lop = 2; lae = 1; lnk = m_ack;
      end
      if (ld) begin m_slot_v = 1; m_slot_op = lop; m_slot_ae = lae; m_slot_nk = lnk; end
      if (wr && ra == 2'd2) begin m_txp = 1; if (!m_seen) m_inval = 1; m_tx = wd; end
      if (wr && ra == 2'd1) begin m_seen = 1; m_addr = wd; end
      if (wr && ra == 2'd0) begin m_ack = wd[2]; m_smart = wd[4]; end
      if (flsh) begin
        {m_slot_v, m_txp, m_busy, m_owned, m_seen, m_inval} = '0;
        e_req = 0; e_fl = 1;
      end
    end
  end

  // per-cycle comparison and request log
  int n_req = 0, n_flush = 0, last_op = -1, prev_op = -1;
  bit [7:0] last_byte; bit last_ae, last_nk, back2back = 0, req_d1 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (e_req || req || e_fl || fl) begin
        n_chk++;
        if (req !== e_req || fl !== e_fl ||
            (e_req && (op !== 3'(e_op) || ack_en !== e_ae || nack !== e_nk ||
                       (e_op <= 1 || e_op == 3) && eb !== e_byte))) begin
          n_fail++;
          $display("FAIL R12 model req=%0b op=%0d ae=%0b nk=%0b byte=%h fl=%0b exp req=%0b op=%0d ae=%0b nk=%0b byte=%h fl=%0b",
                   req, op, ack_en, nack, eb, fl, e_req, e_op, e_ae, e_nk, e_byte, e_fl);
        end
      end
      if (req) begin
        n_req++; prev_op = last_op; last_op = int'(op);
        last_byte = eb; last_ae = ack_en; last_nk = nack;
        if (req_d1) back2back = 1;
      end
      if (fl) n_flush++;
      req_d1 = req;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; ra = a; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, int exp, string tag);
    @(negedge clk); rd = 1'b1; ra = a;
    #2 check(tag, int'(rdv), exp);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_m = 1'b1;
    @(negedge clk); done_m = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int base;
    idle(4); rst_n = 1'b1; idle(5);
    // R1 reset state
    rreg(2'd0, 0, "R1 ctrl"); rreg(2'd3, 0, "R1 status");
    rreg(2'd1, 0, "R1 addr"); rreg(2'd2, 0, "R1 data");
    check("R1 no request", n_req, 0);
    // R8 start waits for a free bus
    wreg(2'd1, 8'h50); idle(6);
    check("R8 held while busy bus", n_req, 0);
    rreg(2'd3, 8'h08, "R11 pending status");
    bus_free = 1'b1; idle(6); bus_free = 1'b0;
    check("R8 start issued", n_req, 1); check("R8 op", last_op, 0);
    check("R8 byte", int'(last_byte), 8'h50);
    // R3 transfer command in write direction requests nothing
    wreg(2'd0, 8'h06); idle(8);
    check("R3 write dir no request", n_req, 1);
    // R7 data write releases byte write
    wreg(2'd2, 8'hA5); idle(8);
    check("R7 write issued", n_req, 2); check("R7 op", last_op, 3);
    check("R7 byte", int'(last_byte), 8'hA5); check("R7 no ack", int'(last_ae), 0);
    // R2 R5 repeated start with NACK in the same write
    wreg(2'd0, 8'h05); idle(8);
    check("R2 rstart op", last_op, 1); check("R5 nack same write", int'(last_nk), 1);
    check("R2 ack driven", int'(last_ae), 1);
    wreg(2'd0, 8'h00); idle(8);
    check("R2 code 0 no request", n_req, 3);
    // R8 owned bus restarts without bus free, then R3 read
    wreg(2'd1, 8'h51); idle(8);
    check("R8 owned start", last_op, 0); check("R8 owned byte", int'(last_byte), 8'h51);
    rx = 8'h3C;
    wreg(2'd0, 8'h02); idle(8);
    check("R3 read op", last_op, 2); check("R3 read ack", int'(last_ae), 1);
    check("R5 ack value", int'(last_nk), 0);
    base = n_req;
    rreg(2'd2, 8'h3C, "R13 rx byte"); idle(6);
    check("R6 smart off no request", n_req, base);
    // R6 smart mode, R4 control readback
    wreg(2'd0, 8'h10);
    rreg(2'd0, 8'h10, "R4 ctrl readback");
    rx = 8'h5A;
    rreg(2'd2, 8'h3C, "R13 old byte"); idle(8);
    check("R6 smart read issued", n_req, base + 1); check("R6 op", last_op, 2);
    check("R6 ack", int'(last_ae), 1); check("R6 nack", int'(last_nk), 0);
    rreg(2'd2, 8'h5A, "R13 new byte");
    // R11 held and overwritten command
    auto_lat = 0;
    wreg(2'd0, 8'h05); idle(3);
    base = n_req;
    wreg(2'd0, 8'h07); idle(3);
    check("R11 held", n_req, base);
    rreg(2'd3, 8'h0D, "R11 status busy+owned+pending");
    wreg(2'd0, 8'h05);
    pulse_done(); idle(4);
    check("R11 overwrite issued", n_req, base + 1); check("R11 op", last_op, 1);
    auto_lat = 3; pulse_done(); idle(4);
    check("R11 no stale stop", n_req, base + 1);
    // R2 stop
    wreg(2'd0, 8'h03); idle(8);
    check("R2 stop op", last_op, 4); check("R2 stop ack", int'(last_ae), 1);
    rreg(2'd3, 0, "R2 stop releases bus");
    // R9 flush
    auto_lat = 0; bus_free = 1'b1;
    wreg(2'd1, 8'h52); idle(4);
    rreg(2'd3, 8'h05, "R9 before flush");
    wreg(2'd0, 8'h00); idle(2);
    rreg(2'd3, 8'h05, "R9 zero flush no effect");
    base = n_req;
    wreg(2'd0, 8'h0B); idle(4);
    check("R9 flush strobe", n_flush, 1);
    check("R9 stop dropped", n_req, base);
    rreg(2'd3, 0, "R9 state cleared");
    pulse_done(); auto_lat = 3; bus_free = 1'b0;
    // R10 data before address
    wreg(2'd2, 8'h77); idle(6);
    rreg(2'd3, 8'h02, "R10 invalid flag");
    check("R10 no early write", n_req, base);
    wreg(2'd1, 8'h20); idle(3);
    rreg(2'd3, 8'h0A, "R10 pending address");
    bus_free = 1'b1; idle(14);
    check("R10 two requests", n_req, base + 2);
    check("R10 address first", prev_op, 0);
    check("R10 data second", last_op, 3);
    check("R10 byte", int'(last_byte), 8'h77);
    check("R12 no back-to-back requests", int'(back2back), 0);
    finished = 1;
    finish_run();
  end
endmodule